// File: doc/BRIEF.md
# Status Channel Receiver with Loss-of-Sync Monitor

This block sits on the flow-control return path of a packet transmitter. It watches a narrow status lane that delivers one 2-bit word per clock. It locks onto the framing word, then walks a programmable calendar of port numbers. Each status word is paired with the port that the calendar names for that slot, and the pair is delivered downstream as a per-port status update. The calendar is read from an external table. Each table word holds four 4-bit port entries and an odd-parity bit.

Every frame ends with a 2-bit check word, and the block verifies it against the data words of that frame. A framing word that turns up where port status was expected is reported and restarts the frame. Two independent run-length counters track consecutive check-word failures and consecutive framing faults. Either counter can declare the link out of sync and silence the block. Software sets a limit for each counter, and a limit of zero switches that check off. Recovery is done by dropping the enable, which clears the fatal flags and starts a new search for the framing word.

Top module: `stat_chan_rx`

## Requirements
- R1: When `en_i` is low or `cal_len_i` is 0, the block is off. From the next clock edge it emits no update and no pulse, and `nosync_o` and `frmerr_o` read 0. After it is enabled, the first edge moves it to the framing search, and words are examined from the edge after that.
- R2: During the framing search, words other than 2'b11 are ignored. After a 2'b11, the next `cal_len_i` × `cal_rep_i` words are status words, where a repeat count of 0 counts as 1. Status word k (counted from 0) produces `upd_valid_o`=1 one cycle later. `upd_port_o` is calendar entry e = k mod `cal_len_i`, taken from table word e/4 at bits [4*(e mod 4)+3 : 4*(e mod 4)]. `upd_status_o` is the received word.
- R3: The word after the last status word is the check word. Its expected value is the bitwise complement of the XOR of all status words of the frame. A mismatch gives a one-cycle `dip_err_o` one cycle later. A check word of 2'b11 is never treated as a framing fault.
- R4: Consecutive check-word mismatches are counted, and a matching check word resets the count to 0. When the count goes beyond a nonzero `dip_lim_i`, `nosync_o` is set one cycle later. With `dip_lim_i`=0 the flag is never set.
- R5: A 2'b11 in a status slot gives a one-cycle `unx_frm_o` and no update. The frame restarts, so the next word is status word 0.
- R6: Consecutive framing faults are counted, and a frame that reaches its check word resets the count to 0. When the count goes beyond a nonzero `frm_lim_i`, `frmerr_o` is set one cycle later. A limit of 0 disables the check.
- R7: `nosync_o` and `frmerr_o` stay set while the block is on. While either flag is set, no update or pulse is produced. Only the off state of R1 clears the flags.
- R8: A table word is valid when the XOR of all 17 bits is 1. Reading a status slot from a table word without that parity gives a one-cycle `cal_par_err_o` and no update, and returns the block to the framing search.
- R9: When bit p of `ign_mask_i` is set, updates for port p carry status 2'b00 (the full-credit code) in place of the received word.
- R10: In any cycle, at most one of `upd_valid_o`, `dip_err_o`, `unx_frm_o` and `cal_par_err_o` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| en_i | input | 1 | Status channel enable |
| stat_i | input | 2 | Status lane word |
| cal_len_i | input | 7 | Calendar length in entries |
| cal_rep_i | input | 8 | Calendar repetitions per frame (0 counts as 1) |
| tbl_addr_o | output | 5 | Calendar table word address |
| tbl_data_i | input | 17 | Table word: parity bit 16, entries in four 4-bit fields |
| dip_lim_i | input | 4 | Consecutive check-word failure limit (0 = off) |
| frm_lim_i | input | 4 | Consecutive framing fault limit (0 = off) |
| ign_mask_i | input | 16 | Per-port ignore mask |
| upd_valid_o | output | 1 | Status update valid |
| upd_port_o | output | 4 | Port of the update |
| upd_status_o | output | 2 | Status of the update |
| dip_err_o | output | 1 | Check-word mismatch pulse |
| unx_frm_o | output | 1 | Misplaced framing word pulse |
| cal_par_err_o | output | 1 | Calendar parity error pulse |
| nosync_o | output | 1 | Lost sync from check-word failures |
| frmerr_o | output | 1 | Lost sync from framing faults |

## Verification
Framing detection and check-word evaluation can both see a 2'b11 in the same cycle. The bench puts that word in the check slot of a frame whose expected check value is 2'b11, and it expects no framing pulse, no mismatch and a fresh frame on the following 2'b11. A framing fault and the framing-limit trip also fall in one cycle. This is driven with a limit of 1 and two misplaced framing words, and the bench checks that the pulse and the fatal flag both appear one cycle later. The exclusivity of the event outputs is also checked on every cycle.

// File: rtl/scr_pkg.sv
package scr_pkg;
  localparam int LIM_W = 4;
  localparam int CNT_W = LIM_W + 1;
  localparam logic [1:0] FRAME_WORD = 2'b11;

  typedef enum logic [2:0] {ST_OFF, ST_HUNT, ST_DATA, ST_DIP, ST_DOWN} rx_state_t;

  // Expected check word: complement of the running XOR of status words.
  function automatic logic [1:0] chk_expect(input logic [1:0] acc);
    return ~acc;
  endfunction

  // True when a consecutive count has gone beyond an enabled limit.
  function automatic logic over_limit(input logic [CNT_W-1:0] cnt,
                                      input logic [LIM_W-1:0] lim);
    return (lim != '0) && (cnt > {1'b0, lim});
  endfunction
endpackage

// File: rtl/scr_cal_walk.sv
module scr_cal_walk #(
  parameter int LEN_W    = 7,
  parameter int REP_W    = 8,
  parameter int PORT_W   = 4,
  parameter int PER_WORD = 4,
  localparam int SLOT_W  = $clog2(PER_WORD),
  localparam int ADDR_W  = LEN_W - SLOT_W,
  localparam int TBL_W   = PER_WORD * PORT_W + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              restart,
  input  logic              advance,
  input  logic [LEN_W-1:0]  len,
  input  logic [REP_W-1:0]  rep,
  output logic [ADDR_W-1:0] tbl_addr,
  input  logic [TBL_W-1:0]  tbl_data,
  output logic [PORT_W-1:0] port,
  output logic              par_ok,
  output logic              last
);
  localparam logic [LEN_W-1:0] ONE_L = 1;
  localparam logic [REP_W-1:0] ONE_R = 1;

  logic [LEN_W-1:0] idx_q;
  logic [REP_W-1:0] rep_q;
  logic [REP_W-1:0] rep_last;
  logic             idx_end;

  assign rep_last = (rep == '0) ? '0 : rep - ONE_R;
  assign idx_end  = (idx_q == len - ONE_L);
  assign last     = idx_end && (rep_q == rep_last);
  assign tbl_addr = idx_q[LEN_W-1:SLOT_W];
  assign par_ok   = ^tbl_data;

  always_comb begin
    port = '0;
    for (int s = 0; s < PER_WORD; s++) begin
      if (idx_q[SLOT_W-1:0] == s[SLOT_W-1:0]) port = tbl_data[s*PORT_W +: PORT_W];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idx_q <= '0;
      rep_q <= '0;
    end else if (restart) begin
      idx_q <= '0;
      rep_q <= '0;
    end else if (advance) begin
      if (idx_end) begin
        idx_q <= '0;
        rep_q <= rep_q + ONE_R;
      end else begin
        idx_q <= idx_q + ONE_L;
      end
    end
  end
endmodule

// File: rtl/scr_err_run.sv
module scr_err_run
  import scr_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             flush,
  input  logic             bump,
  input  logic             good,
  input  logic [LIM_W-1:0] lim,
  output logic             trip
);
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_nx;

  assign cnt_nx = (cnt_q == '1) ? cnt_q : cnt_q + CNT_W'(1);
  assign trip   = bump && over_limit(cnt_nx, lim);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     cnt_q <= '0;
    else if (flush) cnt_q <= '0;
    else if (bump)  cnt_q <= cnt_nx;
    else if (good)  cnt_q <= '0;
  end
endmodule

// File: rtl/stat_chan_rx.sv
module stat_chan_rx
  import scr_pkg::*;
#(
  parameter int PORT_W   = 4,
  parameter int LEN_W    = 7,
  parameter int REP_W    = 8,
  parameter int PER_WORD = 4,
  localparam int SLOT_W  = $clog2(PER_WORD),
  localparam int ADDR_W  = LEN_W - SLOT_W,
  localparam int TBL_W   = PER_WORD * PORT_W + 1,
  localparam int NPORT   = 1 << PORT_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en_i,
  input  logic [1:0]        stat_i,
  input  logic [LEN_W-1:0]  cal_len_i,
  input  logic [REP_W-1:0]  cal_rep_i,
  output logic [ADDR_W-1:0] tbl_addr_o,
  input  logic [TBL_W-1:0]  tbl_data_i,
  input  logic [LIM_W-1:0]  dip_lim_i,
  input  logic [LIM_W-1:0]  frm_lim_i,
  input  logic [NPORT-1:0]  ign_mask_i,
  output logic              upd_valid_o,
  output logic [PORT_W-1:0] upd_port_o,
  output logic [1:0]        upd_status_o,
  output logic              dip_err_o,
  output logic              unx_frm_o,
  output logic              cal_par_err_o,
  output logic              nosync_o,
  output logic              frmerr_o
);
  rx_state_t state_q, state_nx;
  logic [1:0]        acc_q;
  logic              active, is_frame;
  logic              walk_restart, walk_adv, walk_last, par_ok;
  logic [PORT_W-1:0] cal_port;
  // Named internal events, observed by the bound checker.
  logic upd_ev, dip_ev, unx_ev, par_ev;
  logic dip_bump, dip_good, frm_bump, frm_good;
  logic dip_trip, frm_trip;

  assign active   = en_i && (cal_len_i != '0);
  assign is_frame = (stat_i == FRAME_WORD);

  scr_cal_walk #(.LEN_W(LEN_W), .REP_W(REP_W), .PORT_W(PORT_W), .PER_WORD(PER_WORD)) u_walk (
    .clk(clk), .rst_n(rst_n), .restart(walk_restart), .advance(walk_adv),
    .len(cal_len_i), .rep(cal_rep_i), .tbl_addr(tbl_addr_o), .tbl_data(tbl_data_i),
    .port(cal_port), .par_ok(par_ok), .last(walk_last)
  );

  scr_err_run u_dip_run (
    .clk(clk), .rst_n(rst_n), .flush(!active), .bump(dip_bump), .good(dip_good),
    .lim(dip_lim_i), .trip(dip_trip)
  );

  scr_err_run u_frm_run (
    .clk(clk), .rst_n(rst_n), .flush(!active), .bump(frm_bump), .good(frm_good),
    .lim(frm_lim_i), .trip(frm_trip)
  );

  always_comb begin
    state_nx     = state_q;
    walk_restart = 1'b0;
    walk_adv     = 1'b0;
    upd_ev       = 1'b0;
    dip_ev       = 1'b0;
    unx_ev       = 1'b0;
    par_ev       = 1'b0;
    dip_bump     = 1'b0;
    dip_good     = 1'b0;
    frm_bump     = 1'b0;
    frm_good     = 1'b0;
    if (!active) begin
      state_nx = ST_OFF;
    end else begin
      case (state_q)
        ST_OFF:  state_nx = ST_HUNT;
        ST_HUNT: if (is_frame) begin
          walk_restart = 1'b1;
          state_nx     = ST_DATA;
        end
        ST_DATA: if (is_frame) begin
          unx_ev       = 1'b1;
          frm_bump     = 1'b1;
          walk_restart = 1'b1;
          if (frm_trip) state_nx = ST_DOWN;
        end else if (!par_ok) begin
          par_ev   = 1'b1;
          state_nx = ST_HUNT;
        end else begin
          upd_ev   = 1'b1;
          walk_adv = 1'b1;
          if (walk_last) state_nx = ST_DIP;
        end
        ST_DIP: begin
          frm_good = 1'b1;
          if (stat_i == chk_expect(acc_q)) begin
            dip_good = 1'b1;
          end else begin
            dip_ev   = 1'b1;
            dip_bump = 1'b1;
          end
          state_nx = dip_trip ? ST_DOWN : ST_HUNT;
        end
        default: state_nx = ST_DOWN;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q       <= ST_OFF;
      acc_q         <= '0;
      upd_valid_o   <= 1'b0;
      upd_port_o    <= '0;
      upd_status_o  <= '0;
      dip_err_o     <= 1'b0;
      unx_frm_o     <= 1'b0;
      cal_par_err_o <= 1'b0;
      nosync_o      <= 1'b0;
      frmerr_o      <= 1'b0;
    end else begin
      state_q       <= state_nx;
      if (walk_restart) acc_q <= '0;
      else if (upd_ev)  acc_q <= acc_q ^ stat_i;
      upd_valid_o   <= upd_ev;
      upd_port_o    <= cal_port;
      upd_status_o  <= ign_mask_i[cal_port] ? 2'b00 : stat_i;
      dip_err_o     <= dip_ev;
      unx_frm_o     <= unx_ev;
      cal_par_err_o <= par_ev;
      nosync_o      <= active && (nosync_o || dip_trip);
      frmerr_o      <= active && (frmerr_o || frm_trip);
    end
  end
endmodule

// File: rtl/stat_chan_rx_chk.sv
module stat_chan_rx_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        en_i,
  input logic [6:0]  cal_len_i,
  input logic [3:0]  dip_lim_i,
  input logic [15:0] ign_mask_i,
  input logic        upd_valid_o,
  input logic [3:0]  upd_port_o,
  input logic [1:0]  upd_status_o,
  input logic        dip_err_o,
  input logic        unx_frm_o,
  input logic        cal_par_err_o,
  input logic        nosync_o,
  input logic        frmerr_o,
  input logic        dip_trip,
  input logic        frm_trip
);
  logic [15:0] ign_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ign_q <= '0;
    else        ign_q <= ign_mask_i;
  end

  a_r1_off_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !en_i |=> (!upd_valid_o && !nosync_o && !frmerr_o && !dip_err_o));

  a_r10_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({upd_valid_o, dip_err_o, unx_frm_o, cal_par_err_o}));

  a_r9_ignored_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (upd_valid_o && ign_q[upd_port_o]) |-> (upd_status_o == 2'b00));

  a_r7_down_silent: assert property (@(posedge clk) disable iff (!rst_n)
    (nosync_o || frmerr_o) |-> !upd_valid_o);

  a_r7_flag_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (nosync_o && en_i && cal_len_i != 7'd0) |=> nosync_o);

  a_r4_trip_sets_flag: assert property (@(posedge clk) disable iff (!rst_n)
    (dip_trip && en_i && cal_len_i != 7'd0) |=> nosync_o);

  a_r6_trip_sets_flag: assert property (@(posedge clk) disable iff (!rst_n)
    (frm_trip && en_i && cal_len_i != 7'd0) |=> (frmerr_o && unx_frm_o));

  a_r4_zero_limit: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(nosync_o) |-> ($past(dip_lim_i) != 4'd0));
endmodule

bind stat_chan_rx stat_chan_rx_chk u_chk (
  .clk(clk), .rst_n(rst_n), .en_i(en_i), .cal_len_i(cal_len_i), .dip_lim_i(dip_lim_i),
  .ign_mask_i(ign_mask_i), .upd_valid_o(upd_valid_o), .upd_port_o(upd_port_o),
  .upd_status_o(upd_status_o), .dip_err_o(dip_err_o), .unx_frm_o(unx_frm_o),
  .cal_par_err_o(cal_par_err_o), .nosync_o(nosync_o), .frmerr_o(frmerr_o),
  .dip_trip(dip_trip), .frm_trip(frm_trip)
);

// File: tb/stat_chan_rx_bench.sv
`timescale 1ns/1ps
module stat_chan_rx_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        en = 1'b0;
  logic [1:0]  stat = 2'b00;
  logic [6:0]  len = 7'd3;
  logic [7:0]  rep = 8'd2;
  logic [4:0]  taddr;
  logic [16:0] tdata;
  logic [3:0]  dlim = 4'd2;
  logic [3:0]  flim = 4'd2;
  logic [15:0] ign = 16'h0200;
  logic        uv, de, ue, pe, ns, fe;
  logic [3:0]  up;
  logic [1:0]  us;
  logic [16:0] tbl [32];
  int checks = 0;
  int fails = 0;
  bit done = 0;

  always #4 clk = ~clk;

  assign tdata = tbl[taddr];

  stat_chan_rx u_stat_chan_rx (
    .clk(clk), .rst_n(rst_n), .en_i(en), .stat_i(stat), .cal_len_i(len), .cal_rep_i(rep),
    .tbl_addr_o(taddr), .tbl_data_i(tdata), .dip_lim_i(dlim), .frm_lim_i(flim),
    .ign_mask_i(ign), .upd_valid_o(uv), .upd_port_o(up), .upd_status_o(us),
    .dip_err_o(de), .unx_frm_o(ue), .cal_par_err_o(pe), .nosync_o(ns), .frmerr_o(fe)
  );

  // Table word with odd parity over all 17 bits.
  function automatic logic [16:0] with_par(input logic [15:0] d);
    return {~(^d), d};
  endfunction

  // Vector: [10:9] word, [8] valid, [7:4] port, [3:2] status, [1] check err, [0] framing fault
  localparam int NV = 21;
  localparam logic [10:0] VEC [NV] = '{
    {2'd3, 1'b0, 4'd0, 2'd0, 1'b0, 1'b0},
    {2'd1, 1'b1, 4'd5, 2'd1, 1'b0, 1'b0},
    {2'd2, 1'b1, 4'd9, 2'd0, 1'b0, 1'b0},
    {2'd0, 1'b1, 4'd2, 2'd0, 1'b0, 1'b0},
    {2'd2, 1'b1, 4'd5, 2'd2, 1'b0, 1'b0},
    {2'd1, 1'b1, 4'd9, 2'd0, 1'b0, 1'b0},
    {2'd1, 1'b1, 4'd2, 2'd1, 1'b0, 1'b0},
    {2'd2, 1'b0, 4'd0, 2'd0, 1'b0, 1'b0},
    {2'd3, 1'b0, 4'd0, 2'd0, 1'b0, 1'b0},
    {2'd0, 1'b1, 4'd5, 2'd0, 1'b0, 1'b0},
    {2'd0, 1'b1, 4'd9, 2'd0, 1'b0, 1'b0},
    {2'd0, 1'b1, 4'd2, 2'd0, 1'b0, 1'b0},
    {2'd0, 1'b1, 4'd5, 2'd0, 1'b0, 1'b0},
    {2'd0, 1'b1, 4'd9, 2'd0, 1'b0, 1'b0},
    {2'd0, 1'b1, 4'd2, 2'd0, 1'b0, 1'b0},
    {2'd1, 1'b0, 4'd0, 2'd0, 1'b1, 1'b0},
    {2'd3, 1'b0, 4'd0, 2'd0, 1'b0, 1'b0},
    {2'd1, 1'b1, 4'd5, 2'd1, 1'b0, 1'b0},
    {2'd3, 1'b0, 4'd0, 2'd0, 1'b0, 1'b1},
    {2'd2, 1'b1, 4'd5, 2'd2, 1'b0, 1'b0},
    {2'd0, 1'b1, 4'd9, 2'd0, 1'b0, 1'b0}
  };

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  // Drive one word away from the edge; return just after the edge that takes it.
  task automatic send(input logic [1:0] w);
    @(negedge clk);
    stat = w;
    @(posedge clk);
    #1;
  endtask

  // Disable for one cycle, then enable and let the block reach the framing search.
  task automatic relink();
    en = 1'b0;
    send(2'd0);
    en = 1'b1;
    send(2'd0);
  endtask

  // One frame of n copies of d, then a check word that is right or wrong.
  task automatic frame_tx(input logic [1:0] d, input int n, input bit bad);
    logic [1:0] acc = 2'd0;
    logic [1:0] cw;
    send(2'd3);
    for (int i = 0; i < n; i++) begin
      send(d);
      acc = acc ^ d;
    end
    cw = ~acc;
    if (bad) cw = cw ^ 2'd1;
    send(cw);
    chk("R3 check-word result", int'(de), int'(bad));
  endtask

  initial begin
    for (int i = 0; i < 32; i++) tbl[i] = with_par(16'h0000);
    tbl[0] = with_par(16'h7295);
    repeat (3) @(posedge clk);
    #1;
    chk("R1 reset valid", int'(uv), 0);
    chk("R1 reset nosync", int'(ns), 0);
    chk("R1 reset frmerr", int'(fe), 0);
    @(negedge clk);
    rst_n = 1'b1;

    // Disabled: frames are not decoded
    send(2'd3);
    send(2'd1);
    chk("R1 disabled no update", int'(uv), 0);

    // Vector walk: len 3, repeat 2, port 9 ignored
    en = 1'b1;
    send(2'd0);
    for (int v = 0; v < NV; v++) begin
      send(VEC[v][10:9]);
      chk("R2 valid", int'(uv), int'(VEC[v][8]));
      if (VEC[v][8]) begin
        chk("R2 port", int'(up), int'(VEC[v][7:4]));
        chk("R2/R9 status", int'(us), int'(VEC[v][3:2]));
      end
      chk("R3 check err", int'(de), int'(VEC[v][1]));
      chk("R5 framing fault", int'(ue), int'(VEC[v][0]));
      chk("R10 one event", int'($countones({uv, de, ue, pe})) <= 1 ? 1 : 0, 1);
    end

    // Check-word run limit
    len = 7'd2; rep = 8'd1; dlim = 4'd2; flim = 4'd0; ign = 16'h0000;
    relink();
    frame_tx(2'd1, 2, 1'b1);
    frame_tx(2'd1, 2, 1'b1);
    chk("R4 nosync after 2 of limit 2", int'(ns), 0);
    frame_tx(2'd1, 2, 1'b1);
    chk("R4 nosync after 3 of limit 2", int'(ns), 1);
    send(2'd3);
    send(2'd1);
    chk("R7 no update while down", int'(uv), 0);
    chk("R7 flag held", int'(ns), 1);
    relink();
    chk("R7 flag cleared by disable", int'(ns), 0);
    frame_tx(2'd2, 2, 1'b1);
    frame_tx(2'd2, 2, 1'b1);
    frame_tx(2'd2, 2, 1'b0);
    frame_tx(2'd2, 2, 1'b1);
    frame_tx(2'd2, 2, 1'b1);
    chk("R4 good check word clears run", int'(ns), 0);
    dlim = 4'd0;
    for (int i = 0; i < 4; i++) frame_tx(2'd0, 2, 1'b1);
    chk("R4 limit zero never trips", int'(ns), 0);

    // Framing-fault run limit
    flim = 4'd1;
    relink();
    send(2'd3);
    send(2'd1);
    chk("R2 update port", int'(up), 5);
    send(2'd3);
    chk("R5 pulse", int'(ue), 1);
    chk("R6 frmerr after 1 of limit 1", int'(fe), 0);
    send(2'd1);
    chk("R5 restart at entry 0", int'(up), 5);
    send(2'd3);
    chk("R6 pulse on trip", int'(ue), 1);
    chk("R6 frmerr after 2 of limit 1", int'(fe), 1);
    send(2'd0);
    chk("R7 silent after frmerr", int'(uv), 0);
    relink();
    send(2'd3);
    send(2'd3);
    send(2'd1);
    send(2'd1);
    send(2'd2);
    send(2'd3);
    send(2'd3);
    chk("R6 completed frame clears run", int'(fe), 0);

    // Calendar parity
    flim = 4'd0;
    tbl[0] = tbl[0] ^ 17'h10000;
    relink();
    send(2'd3);
    send(2'd1);
    chk("R8 parity pulse", int'(pe), 1);
    chk("R8 no update", int'(uv), 0);
    send(2'd1);
    chk("R8 back to search", int'(uv), 0);
    tbl[0] = with_par(16'h7295);
    send(2'd3);
    send(2'd1);
    chk("R8 good parity update", int'(uv), 1);

    // Repeat count zero counts as one; 2'b11 allowed as check word
    rep = 8'd0;
    relink();
    send(2'd3);
    send(2'd1);
    send(2'd1);
    chk("R2 second entry port", int'(up), 9);
    send(2'd3);
    chk("R3 check word 11 accepted", int'(de), 0);
    chk("R3 check word 11 not a fault", int'(ue), 0);
    send(2'd3);
    send(2'd2);
    chk("R2 new frame after rep 0", int'(up), 5);
    chk("R2 new frame status", int'(us), 2);

    // Zero calendar length keeps the block off
    len = 7'd0;
    send(2'd3);
    send(2'd1);
    chk("R1 zero length no update", int'(uv), 0);

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual running expected finished");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule